// File: doc/BRIEF.md
# Distributed Triple-Redundant Accumulator Stage

This block is a registered accumulator built three times over. Each of the three copies has its own adder and hold logic, its own state register and its own bitwise majority voter. Every voter reads all three registers. Each copy computes its next state from its own voter's output, not from its own register. A bit flip in one register is therefore hidden at the outputs in the cycle it appears, and it is overwritten at the next clock edge.

The primary inputs and outputs are either shared or carried as three separate copies. The `TRIPLE_IO` parameter selects which. With triplicated inputs, copy k reads slice k of the enable and data buses, so a corrupted input copy is also voted away. Each copy has a fault-injection mask for verification. A non-zero mask is XORed into that copy's register at one clock edge. A disagreement flag shows when the three registers differ.

Top module: `tmr_acc_stage`

## Requirements
- R1: On a clock edge with reset low and enable high, the voted value becomes (voted value + data) modulo 2^W. With enable low it holds. The new value is visible on `q` after that same edge.
- R2: A non-zero `flip_mask` slice k is XORed into copy k's register at that edge. When only one copy is upset, every slice of `q` still equals the fault-free value.
- R3: There are three voters, each taking the bitwise majority of the three registers. With `TRIPLE_IO`=1, `q` slice k (bits k*W up to k*W+W-1) comes from voter k, and all three slices are equal.
- R4: Each copy's next state is computed from its voter's output. A single upset copy therefore agrees with the others again one clock edge later, if that edge carries no new fault.
- R5: `disagree` is 1 exactly while the three registers do not all hold the same value. It cannot rise without a fault at the edge before.
- R6: Reset is synchronous and active high. It loads `RST_VAL` into all three copies and takes priority over enable and over the injection masks, so `disagree` is 0 after a reset edge.
- R7: With `TRIPLE_IO`=1, copy k takes `en` bit k and `din` slice k, and a wrong value on one input copy does not change `q`. With `TRIPLE_IO`=0, `en` is 1 bit, `din` and `q` are W bits, and all copies share them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, shared by all copies |
| en | input | NIO (3 or 1) | Accumulate enable, one bit per input copy |
| din | input | NIO*W | Addend, one W-bit slice per input copy |
| flip_mask | input | 3*W | Per-copy fault-injection mask; slice k upsets copy k |
| q | output | NIO*W | Voted accumulator value, one slice per output copy |
| disagree | output | 1 | High while the three registers differ |

## Verification
Each result is due one clock edge after its stimulus:
- The accumulated value on `q`, the masked fault and the `disagree` flag raised by an injection or by a bad input copy all appear after the edge that takes the stimulus.
- The scrubbing of that fault appears after the following edge.

The bench drives inputs on the falling edge. It samples at the next falling edge, after exactly one rising edge, and compares against a running model that only ever applies fault-free data. Directed steps cover reset during injection, faults on two different copies in consecutive cycles, and a disagreeing enable copy.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned NCOPY = 3;

  // One-bit majority of three.
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = tmr_pkg::maj3(a[i], b[i], c[i]);
  end
endmodule

// File: rtl/tmr_lane.sv
module tmr_lane #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  input  logic [W-1:0] fb,     // voted value of this copy
  input  logic [W-1:0] flip,   // fault-injection mask
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] step(input logic [W-1:0] cur,
                                        input logic e,
                                        input logic [W-1:0] add);
    return e ? cur + add : cur;
  endfunction

  logic [W-1:0] nxt;
  assign nxt = step(fb, en, din);

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= nxt ^ flip;
  end
endmodule

// File: rtl/tmr_disagree.sv
module tmr_disagree #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic         diff
);
  assign diff = (a != b) | (b != c);
endmodule

// File: rtl/tmr_acc_stage.sv
module tmr_acc_stage #(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] RST_VAL  = '0,
  parameter bit          TRIPLE_IO = 1'b1,
  localparam int unsigned NIO     = TRIPLE_IO ? tmr_pkg::NCOPY : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NIO-1:0]              en,
  input  logic [NIO*W-1:0]            din,
  input  logic [tmr_pkg::NCOPY*W-1:0] flip_mask,
  output logic [NIO*W-1:0]            q,
  output logic                        disagree
);
  localparam int unsigned NC = tmr_pkg::NCOPY;

  // Named internal events for the checker.
  logic [NC-1:0][W-1:0] lane_q;
  logic [NC-1:0][W-1:0] vote_v;
  logic [NC-1:0]        inj_hit;
  logic                 in_agree;

  for (genvar k = 0; k < NC; k++) begin : g_copy
    localparam int unsigned IX = TRIPLE_IO ? k : 0;

    tmr_voter #(.W(W)) u_vote (
      .a(lane_q[0]), .b(lane_q[1]), .c(lane_q[2]), .y(vote_v[k])
    );

    tmr_lane #(.W(W), .RST_VAL(RST_VAL)) u_lane (
      .clk (clk),
      .rst (rst),
      .en  (en[IX]),
      .din (din[IX*W +: W]),
      .fb  (vote_v[k]),
      .flip(flip_mask[k*W +: W]),
      .q   (lane_q[k])
    );

    assign inj_hit[k] = |flip_mask[k*W +: W];
  end

  for (genvar k = 0; k < NIO; k++) begin : g_out
    assign q[k*W +: W] = vote_v[k];
  end

  if (TRIPLE_IO) begin : g_in3
    assign in_agree = (en[0] == en[1]) && (en[1] == en[2]) &&
                      (din[0 +: W] == din[W +: W]) && (din[W +: W] == din[2*W +: W]);
  end else begin : g_in1
    assign in_agree = 1'b1;
  end

  tmr_disagree #(.W(W)) u_cmp (
    .a(lane_q[0]), .b(lane_q[1]), .c(lane_q[2]), .diff(disagree)
  );
endmodule

// File: rtl/tmr_acc_stage_chk.sv
module tmr_acc_stage_chk #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter int unsigned NIO     = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NIO-1:0]       en,
  input logic [NIO*W-1:0]     din,
  input logic                 disagree,
  input logic [2:0][W-1:0]    lane_q,
  input logic [2:0][W-1:0]    vote_v,
  input logic [2:0]           inj_hit,
  input logic                 in_agree
);
  typedef logic [W-1:0] word_t;

  // R1: voted value follows the accumulate rule under at most one fault.
  assert_track_R1: assert property (@(posedge clk) disable iff (rst)
    (in_agree && $countones(inj_hit) <= 1) |=>
      vote_v[0] == word_t'($past(vote_v[0]) + ($past(en[0]) ? $past(din[W-1:0]) : '0)));

  // R2: an injected flip is visible as a disagreement.
  assert_flip_seen_R2: assert property (@(posedge clk) disable iff (rst)
    (in_agree && $countones(inj_hit) == 1) |=> disagree);

  // R3: all three voters yield the same value.
  assert_voters_agree_R3: assert property (@(posedge clk) disable iff (rst)
    (vote_v[0] == vote_v[1]) && (vote_v[1] == vote_v[2]));

  // R4: a fault-free edge leaves all copies agreeing.
  assert_scrub_R4: assert property (@(posedge clk) disable iff (rst)
    (inj_hit == '0 && in_agree) |=> !disagree);

  // R5: a disagreement only starts after a fault.
  assert_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(disagree) |-> $past(inj_hit != '0 || !in_agree));

  // R6: reset loads every copy with the reset value.
  assert_reset_R6: assert property (@(posedge clk)
    rst |=> (lane_q[0] == RST_VAL && lane_q[1] == RST_VAL && lane_q[2] == RST_VAL));
endmodule

bind tmr_acc_stage tmr_acc_stage_chk #(.W(W), .RST_VAL(RST_VAL), .NIO(NIO)) u_chk (
  .clk(clk), .rst(rst), .en(en), .din(din), .disagree(disagree),
  .lane_q(lane_q), .vote_v(vote_v), .inj_hit(inj_hit), .in_agree(in_agree)
);

// File: tb/tmr_acc_stage_tb.sv
module tmr_acc_stage_tb;
  localparam int unsigned W = 8;
  localparam logic [W-1:0] RV = 8'h3C;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic             rst;
  logic [2:0]       en3;
  logic [3*W-1:0]   din3;
  logic [3*W-1:0]   flip;
  logic [3*W-1:0]   q3;
  logic             dis3;
  logic             en1;
  logic [W-1:0]     din1;
  logic [W-1:0]     q1;
  logic             dis1;

  tmr_acc_stage #(.W(W), .RST_VAL(RV), .TRIPLE_IO(1'b1)) u_dut (
    .clk(clk), .rst(rst), .en(en3), .din(din3), .flip_mask(flip),
    .q(q3), .disagree(dis3)
  );

  tmr_acc_stage #(.W(W), .RST_VAL(RV), .TRIPLE_IO(1'b0)) u_dut_s (
    .clk(clk), .rst(rst), .en(en1), .din(din1), .flip_mask('0),
    .q(q1), .disagree(dis1)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] model;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Vector: {en, din, fault lane (3 = none), fault mask, bad input lane (3 = none)}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'h05, 2'd3, 8'h00, 2'd3},
    {1'b1, 8'h10, 2'd0, 8'h01, 2'd3},
    {1'b0, 8'h33, 2'd3, 8'h00, 2'd3},
    {1'b1, 8'h80, 2'd1, 8'hFF, 2'd3},
    {1'b1, 8'hFF, 2'd2, 8'h80, 2'd3},
    {1'b1, 8'h01, 2'd3, 8'h00, 2'd0},
    {1'b0, 8'h00, 2'd0, 8'h0F, 2'd3},
    {1'b1, 8'h7F, 2'd3, 8'h00, 2'd2},
    {1'b1, 8'h22, 2'd3, 8'h00, 2'd3},
    {1'b1, 8'hC4, 2'd1, 8'h24, 2'd3},
    {1'b0, 8'h99, 2'd3, 8'h00, 2'd1},
    {1'b1, 8'h11, 2'd3, 8'h00, 2'd3}
  };

  task automatic drive(input logic e, input logic [W-1:0] d,
                       input logic [1:0] fl, input logic [W-1:0] fm,
                       input logic [1:0] bl);
    en3  = {3{e}};
    din3 = {3{d}};
    if (bl != 2'd3) din3[bl*W +: W] = d ^ 8'h5A;
    flip = '0;
    if (fl != 2'd3) flip[fl*W +: W] = fm;
    en1  = e;
    din1 = d;
  endtask

  task automatic check_q(input string tag);
    for (int k = 0; k < 3; k++) check(tag, q3[k*W +: W], model);
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, '0, 2'd3, '0, 2'd3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    model = RV;
    check_q("R6 reset value");
    check("R6 disagree after reset", dis3, 0);
    check("R7 shared-port reset value", q1, RV);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      logic fault;
      v = VEC[i];
      drive(v[20], v[19:12], v[11:10], v[9:2], v[1:0]);
      fault = (v[11:10] != 2'd3 && v[9:2] != '0) || (v[1:0] != 2'd3 && v[20]);
      @(posedge clk);
      @(negedge clk);
      if (v[20]) model = model + v[19:12];
      if (fault) begin
        check_q("R2 voted value masks single fault");
        check("R5 disagree raised by fault", dis3, 1);
      end else begin
        check_q("R1 accumulate");
        check("R4 copies agree after clean edge", dis3, 0);
      end
      check("R7 shared-port instance", q1, model);
    end

    // R6: reset overrides injection and enable.
    rst = 1'b1;
    drive(1'b1, 8'h05, 2'd3, '0, 2'd3);
    flip = {3*W{1'b1}};
    @(posedge clk); @(negedge clk);
    model = RV;
    check_q("R6 reset beats injection");
    check("R6 no disagree after reset", dis3, 0);
    rst = 1'b0;

    // R4: faults on two copies in consecutive cycles.
    drive(1'b0, '0, 2'd0, 8'h01, 2'd3);
    @(posedge clk); @(negedge clk);
    check("R2 copy 0 upset masked", q3[0 +: W], model);
    drive(1'b0, '0, 2'd2, 8'h10, 2'd3);
    @(posedge clk); @(negedge clk);
    check_q("R4 second fault, first already scrubbed");
    check("R5 disagree on second fault", dis3, 1);
    drive(1'b0, '0, 2'd3, '0, 2'd3);
    @(posedge clk); @(negedge clk);
    check("R4 scrubbed one edge later", dis3, 0);

    // R7: one enable copy disagrees.
    drive(1'b1, 8'h09, 2'd3, '0, 2'd3);
    en3[1] = 1'b0;
    @(posedge clk); @(negedge clk);
    model = model + 8'h09;
    check_q("R7 bad enable copy voted away");
    check("R7 bad enable copy seen", dis3, 1);
    drive(1'b0, '0, 2'd3, '0, 2'd3);
    @(posedge clk); @(negedge clk);
    check("R3 output slice 2 matches model", q3[2*W +: W], model);
    check("R4 clean after input fault", dis3, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule